// File: doc/BRIEF.md
# Audio Master Clock Divider

This block runs from a master clock at 256 times the audio sample rate (fs), which an upstream PLL already provides. From it the block derives the serial bit clock and the once-per-sample frame clock that a master-mode serial audio port drives toward a converter or a host. It also passes a gated copy of the master clock to an output pin.

Four configuration inputs control the block:
- the bit-clock ratio, which can be 16fs, 32fs or 64fs;
- the shape of the frame clock, which is either a square wave or a pulse one bit wide;
- the enable for the master-clock output;
- whether the serial format is DSP mode.

The block checks every combination of these inputs. An unsupported combination does not run. Instead the block raises `config_error` and holds the bit clock and the frame clock low. A change from one legal setting to another takes effect only where a frame starts, so the serial interface never sees a shortened pulse.

Top module: `audio_clk_div`

## Requirements
- R1: While `mclk_en` is 1, `mclk_out` follows `clk_256fs`. While `mclk_en` is 0, `mclk_out` stays low.
- R2: The bit-clock select `bclk_sel` is decoded as follows: 2'b00 gives a bit-clock period of 16 master cycles (16fs), 2'b01 gives 8 cycles (32fs) and 2'b10 gives 4 cycles (64fs). In every case the bit clock is high for half of its period.
- R3: The frame clock `fclk_out` has a period of 256 master cycles (1fs).
- R4: When `frame_pulse` is 0, the frame clock is high for 128 master cycles of each frame.
- R5: When `frame_pulse` is 1 and `dsp_mode` is 1, the frame clock is high for exactly one bit-clock period in each frame.
- R6: Every change of the frame clock happens in the same master cycle as a falling edge of the bit clock.
- R7: `bclk_sel` = 2'b11 raises `config_error`.
- R8: `frame_pulse` = 1 while `dsp_mode` = 0 raises `config_error`.
- R9: `bclk_sel` = 2'b00 while `dsp_mode` = 0 raises `config_error`. The 32fs and 64fs ratios with `frame_pulse` = 0 are legal outside DSP mode.
- R10: While `config_error` is high, `bclk_out` and `fclk_out` are low. Once the configuration becomes legal, the outputs start a fresh frame, and the first bit-clock high phase has full width.
- R11: A change between two legal configurations takes effect only at the next frame boundary. Until that boundary the old bit-clock ratio stays on the outputs.
- R12: While reset is asserted, `bclk_out`, `fclk_out`, `mclk_out` and `config_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_256fs | input | 1 | Master clock at 256fs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bclk_sel | input | 2 | Bit-clock ratio select: 00 = 16fs, 01 = 32fs, 10 = 64fs, 11 = illegal |
| frame_pulse | input | 1 | Frame-clock shape: 0 = 50% square wave, 1 = one-bit pulse (DSP mode only) |
| mclk_en | input | 1 | Enables the master clock on `mclk_out` |
| dsp_mode | input | 1 | High when the serial format is DSP mode |
| mclk_out | output | 1 | Gated copy of the master clock |
| bclk_out | output | 1 | Bit clock |
| fclk_out | output | 1 | Frame clock |
| config_error | output | 1 | High while the configuration inputs are illegal |

## Verification
The hardest case to reach from the ports is a configuration change made in the middle of a frame. The new ratio has to be staged and must not reach the outputs before the wrap. To get there, the stimulus waits for a rising edge of the frame clock and then moves the select 40 cycles into the frame. It measures the bit-clock period over a window that ends before the next boundary, and measures it again after that boundary. A second hard case is the recovery from an illegal setting. That test drives a legal code out of an error state and checks that the first high phase of the bit clock has full width and that the frame clock restarts cleanly.

// File: rtl/acd_pkg.sv
package acd_pkg;

  typedef enum logic [1:0] {
    BCLK_16FS = 2'b00,
    BCLK_32FS = 2'b01,
    BCLK_64FS = 2'b10,
    BCLK_RSVD = 2'b11
  } bclk_sel_e;

  typedef struct packed {
    bclk_sel_e sel;
    logic      pulse;
    logic      dsp;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_DEFAULT = '{sel: BCLK_16FS, pulse: 1'b0, dsp: 1'b1};

  // Legality rules: reserved ratio, pulse frame outside DSP, 16fs outside DSP
  function automatic logic cfg_illegal(input clk_cfg_t c);
    logic bad;
    bad = 1'b0;
    if (c.sel == BCLK_RSVD)                bad = 1'b1;
    if (c.pulse && !c.dsp)                 bad = 1'b1;
    if ((c.sel == BCLK_16FS) && !c.dsp)    bad = 1'b1;
    return bad;
  endfunction

endpackage

// File: rtl/acd_rst_sync.sv
module acd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/acd_cfg_check.sv
module acd_cfg_check
  import acd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_cfg_t cfg_i,
  output logic     cfg_bad_o,
  output logic     err_q_o
);
  logic err_d;
  logic err_q;

  always_comb begin
    cfg_bad_o = cfg_illegal(cfg_i);
    err_d     = cfg_bad_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_q_o = err_q;
endmodule

// File: rtl/acd_frame_counter.sv
module acd_frame_counter
  import acd_pkg::*;
#(
  parameter int FRAME_LOG2 = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  clk_cfg_t              cfg_i,
  input  logic                  cfg_bad_i,
  input  logic                  err_q_i,
  output logic [FRAME_LOG2-1:0] cnt_o,
  output clk_cfg_t              act_o,
  output logic                  hold_o
);
  logic [FRAME_LOG2-1:0] cnt_q, cnt_d;
  clk_cfg_t              act_q;
  logic                  armed_q, armed_d;
  logic                  wrap;
  logic                  act_en;
  logic                  hold;

  always_comb begin
    hold    = cfg_bad_i | err_q_i | ~armed_q;
    wrap    = (cnt_q == '1);
    act_en  = hold | wrap;
    armed_d = 1'b1;
    if (hold) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= CFG_DEFAULT;
    else if (act_en) act_q <= cfg_i;
  end

  assign cnt_o  = cnt_q;
  assign act_o  = act_q;
  assign hold_o = hold;

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> (($past(cnt_q) == '1) || $past(hold))); // R11
endmodule

// File: rtl/acd_edge_shaper.sv
module acd_edge_shaper
  import acd_pkg::*;
#(
  parameter int FRAME_LOG2    = 8,
  parameter int BASE_DIV_LOG2 = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [FRAME_LOG2-1:0] cnt_i,
  input  clk_cfg_t              act_i,
  input  logic                  hold_i,
  input  logic                  err_q_i,
  output logic                  bclk_o,
  output logic                  fclk_o
);
  localparam int NUM_RATIOS = 3;

  logic [NUM_RATIOS-1:0] bit_tap;
  logic [NUM_RATIOS-1:0] first_bit;
  logic [1:0]            ridx;
  logic                  bclk_q, bclk_d;
  logic                  fclk_q, fclk_d;

  // Ratio s divides by 2**(BASE_DIV_LOG2-s)
  for (genvar s = 0; s < NUM_RATIOS; s++) begin : g_ratio
    assign bit_tap[s]   = cnt_i[BASE_DIV_LOG2-1-s];
    assign first_bit[s] = ((cnt_i >> (BASE_DIV_LOG2 - s)) == '0);
  end

  always_comb begin
    ridx = (act_i.sel == BCLK_RSVD) ? 2'd0 : act_i.sel;
    if (hold_i) begin
      bclk_d = 1'b0;
      fclk_d = 1'b0;
    end else begin
      bclk_d = bit_tap[ridx];
      fclk_d = act_i.pulse ? first_bit[ridx] : ~cnt_i[FRAME_LOG2-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      bclk_q <= bclk_d;
      fclk_q <= fclk_d;
    end
  end

  assign bclk_o = bclk_q;
  assign fclk_o = fclk_q;

  AST_QUIET_ON_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q_i |-> (!bclk_q && !fclk_q)); // R10
  AST_FRAME_EDGE_BCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fclk_q != $past(fclk_q)) && !err_q_i && !$past(err_q_i)) |-> !bclk_q); // R6
  AST_BCLK_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bclk_q) && !err_q_i) |-> $past(bclk_q, 2)); // R11
  AST_ACTIVE_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_q_i && !hold_i) |-> (act_i.sel != BCLK_RSVD)); // R7
endmodule

// File: rtl/acd_mclk_gate.sv
module acd_mclk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_lo_q;

  // Enable captured while the clock is low, so the AND cannot glitch
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_lo_q <= 1'b0;
    else         en_lo_q <= en_i;
  end

  assign clk_o = clk_i & en_lo_q;
endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
  import acd_pkg::*;
#(
  parameter int FRAME_LOG2    = 8,
  parameter int BASE_DIV_LOG2 = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_256fs,
  input  logic       rst_n,
  input  logic [1:0] bclk_sel,
  input  logic       frame_pulse,
  input  logic       mclk_en,
  input  logic       dsp_mode,
  output logic       mclk_out,
  output logic       bclk_out,
  output logic       fclk_out,
  output logic       config_error
);
  logic                  rst_sync_n;
  clk_cfg_t              cfg_in;
  clk_cfg_t              act_cfg;
  logic                  cfg_bad;
  logic                  err_q;
  logic                  hold;
  logic [FRAME_LOG2-1:0] cnt;

  always_comb begin
    cfg_in.sel   = bclk_sel_e'(bclk_sel);
    cfg_in.pulse = frame_pulse;
    cfg_in.dsp   = dsp_mode;
  end

  acd_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i  (clk_256fs),
    .arst_ni(rst_n),
    .rst_no (rst_sync_n)
  );

  acd_cfg_check i_cfg_check (
    .clk_i    (clk_256fs),
    .rst_ni   (rst_sync_n),
    .cfg_i    (cfg_in),
    .cfg_bad_o(cfg_bad),
    .err_q_o  (err_q)
  );

  acd_frame_counter #(.FRAME_LOG2(FRAME_LOG2)) i_frame_counter (
    .clk_i    (clk_256fs),
    .rst_ni   (rst_sync_n),
    .cfg_i    (cfg_in),
    .cfg_bad_i(cfg_bad),
    .err_q_i  (err_q),
    .cnt_o    (cnt),
    .act_o    (act_cfg),
    .hold_o   (hold)
  );

  acd_edge_shaper #(
    .FRAME_LOG2   (FRAME_LOG2),
    .BASE_DIV_LOG2(BASE_DIV_LOG2)
  ) i_edge_shaper (
    .clk_i  (clk_256fs),
    .rst_ni (rst_sync_n),
    .cnt_i  (cnt),
    .act_i  (act_cfg),
    .hold_i (hold),
    .err_q_i(err_q),
    .bclk_o (bclk_out),
    .fclk_o (fclk_out)
  );

  acd_mclk_gate i_mclk_gate (
    .clk_i (clk_256fs),
    .rst_ni(rst_sync_n),
    .en_i  (mclk_en),
    .clk_o (mclk_out)
  );

  assign config_error = err_q;
endmodule

// File: tb/test_audio_clk_div.sv
module test_audio_clk_div;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bclk_sel;
  logic       frame_pulse;
  logic       mclk_en;
  logic       dsp_mode;
  logic       mclk_out, bclk_out, fclk_out, config_error;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int b_per, b_hi, b_hi_min, f_per, f_hi, misalign, high_seen, err_ones;

  always #2 clk = ~clk;

  audio_clk_div i_audio_clk_div (
    .clk_256fs   (clk),
    .rst_n       (rst_n),
    .bclk_sel    (bclk_sel),
    .frame_pulse (frame_pulse),
    .mclk_en     (mclk_en),
    .dsp_mode    (dsp_mode),
    .mclk_out    (mclk_out),
    .bclk_out    (bclk_out),
    .fclk_out    (fclk_out),
    .config_error(config_error)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] sel, input logic pulse, input logic dsp);
    @(negedge clk);
    bclk_sel    = sel;
    frame_pulse = pulse;
    dsp_mode    = dsp;
  endtask

  task automatic observe(input int n);
    logic pb, pf;
    int   br, fr;
    br = -1; fr = -1;
    b_per = 0; b_hi = 0; b_hi_min = 1000; f_per = 0; f_hi = 0;
    misalign = 0; high_seen = 0; err_ones = 0;
    @(negedge clk);
    pb = bclk_out; pf = fclk_out;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (bclk_out && !pb) begin
        if (br >= 0) b_per = i - br;
        br = i;
      end
      if (!bclk_out && pb && br >= 0) begin
        b_hi = i - br;
        if (b_hi < b_hi_min) b_hi_min = b_hi;
      end
      if (fclk_out && !pf) begin
        if (fr >= 0) f_per = i - fr;
        fr = i;
      end
      if (!fclk_out && pf && fr >= 0) f_hi = i - fr;
      if ((fclk_out != pf) && !(pb && !bclk_out)) misalign++;
      if (bclk_out || fclk_out) high_seen++;
      if (config_error) err_ones++;
      pb = bclk_out; pf = fclk_out;
    end
  endtask

  task automatic wait_frame_start();
    logic pf;
    @(negedge clk);
    pf = fclk_out;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (fclk_out && !pf) break;
      pf = fclk_out;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bclk_sel = 2'b00; frame_pulse = 1'b0; mclk_en = 1'b1; dsp_mode = 1'b1;
    wait_cycles(5);
    chk(!bclk_out && !fclk_out && !config_error && !mclk_out, "R12", "outputs in reset",
        {bclk_out, fclk_out, config_error, mclk_out}, 0);
    rst_n = 1'b1;
    mclk_en = 1'b0;
    wait_cycles(5);
  endtask

  task automatic t_ratio(input logic [1:0] sel, input int per);
    set_cfg(sel, 1'b0, 1'b1);
    wait_cycles(300);
    observe(700);
    chk(b_per == per, "R2", "bclk period", b_per, per);
    chk(b_hi == per / 2, "R2", "bclk high width", b_hi, per / 2);
    chk(f_per == 256, "R3", "fclk period", f_per, 256);
    chk(f_hi == 128, "R4", "fclk high width", f_hi, 128);
    chk(misalign == 0, "R6", "fclk edges off bclk fall", misalign, 0);
    chk(err_ones == 0, "R2", "config_error on legal ratio", err_ones, 0);
  endtask

  task automatic t_pulse(input logic [1:0] sel, input int per);
    set_cfg(sel, 1'b1, 1'b1);
    wait_cycles(300);
    observe(700);
    chk(f_hi == per, "R5", "pulse frame width", f_hi, per);
    chk(f_per == 256, "R3", "pulse frame period", f_per, 256);
    chk(misalign == 0, "R6", "pulse edges off bclk fall", misalign, 0);
  endtask

  task automatic t_illegal(input logic [1:0] sel, input logic pulse, input logic dsp,
                           input string req);
    set_cfg(sel, pulse, dsp);
    wait_cycles(4);
    observe(300);
    chk(err_ones == 299, req, "config_error held", err_ones, 299);
    chk(high_seen == 0, "R10", "clocks high during error", high_seen, 0);
  endtask

  task automatic t_legal_nondsp();
    set_cfg(2'b01, 1'b0, 1'b0);
    wait_cycles(4);
    observe(600);
    chk(err_ones == 0, "R9", "32fs non-DSP flagged", err_ones, 0);
    chk(b_per == 8, "R9", "32fs non-DSP bclk period", b_per, 8);
  endtask

  task automatic t_recover();
    set_cfg(2'b11, 1'b0, 1'b1);
    wait_cycles(20);
    set_cfg(2'b10, 1'b1, 1'b1);
    observe(600);
    chk(b_hi_min == 2, "R10", "first bclk high after error", b_hi_min, 2);
    chk(b_per == 4, "R10", "bclk period after error", b_per, 4);
    chk(config_error == 1'b0, "R10", "error cleared", config_error, 0);
  endtask

  task automatic t_boundary();
    set_cfg(2'b00, 1'b0, 1'b1);
    wait_cycles(600);
    wait_frame_start();
    wait_cycles(40);
    set_cfg(2'b10, 1'b0, 1'b1);
    observe(150);
    chk(b_per == 16, "R11", "old ratio before boundary", b_per, 16);
    wait_frame_start();
    observe(200);
    chk(b_per == 4, "R11", "new ratio after boundary", b_per, 4);
  endtask

  task automatic t_mclk();
    mclk_en = 1'b1;
    wait_cycles(3);
    @(posedge clk); #1;
    chk(mclk_out == 1'b1, "R1", "mclk high phase when enabled", mclk_out, 1);
    @(negedge clk); #1;
    chk(mclk_out == 1'b0, "R1", "mclk low phase when enabled", mclk_out, 0);
    mclk_en = 1'b0;
    wait_cycles(3);
    @(posedge clk); #1;
    chk(mclk_out == 1'b0, "R1", "mclk gated off", mclk_out, 0);
  endtask

  initial begin
    t_reset();
    t_mclk();
    t_ratio(2'b00, 16);
    t_ratio(2'b01, 8);
    t_ratio(2'b10, 4);
    t_pulse(2'b01, 8);
    t_pulse(2'b10, 4);
    t_illegal(2'b11, 1'b0, 1'b1, "R7");
    t_illegal(2'b01, 1'b1, 1'b0, "R8");
    t_illegal(2'b00, 1'b0, 1'b0, "R9");
    t_legal_nondsp();
    t_recover();
    t_boundary();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule